// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for a 64-bit processor core. A lookup carries an access mask (read, write, execute) and a two-bit privilege mode index, in which mode 0 is kernel. The walker first checks that the address is canonical. It then recognises a direct-mapped kernel window that needs no memory access. Any other address goes through a three-level table walk on a 64-bit read port, starting from a table base input.

A result arrives as a one-cycle done pulse. The pulse carries a fault code, the physical address (page frame joined with the page offset) and the rights that were granted. A zero access mask serves debug lookups: it returns the translation and never raises a permission fault. The page size is 8 KiB.

Top module: `ptw_walker`

## Requirements
- R1: An address whose bits 63 down to 43 are not all equal gives fault code 1 (access violation) with no memory read. Done rises two cycles after the request is accepted.
- R2: An address with bit 63 set and bits 42:41 equal to 2'b10 is the kernel window. In mode 0 it returns fault code 0 with no memory read. The physical address takes VA bits 39:0 and places VA bit 40 at physical bit 43. The rights are 3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R3: A kernel-window address with a mode index other than 0 gives fault code 1.
- R4: The walk reads the level-1 entry at base + 8*VA[42:33], the level-2 entry at its table + 8*VA[32:23] and the level-3 entry at its table + 8*VA[22:13]. Each next table, and the final frame, is PTE[63:32] shifted left by 13. The returned physical address is that frame with VA[12:0] added.
- R5: A PTE whose bit 0 (valid) is clear, at any level, ends the walk with fault code 2 (not valid) and issues no further reads.
- R6: A level-1 or level-2 PTE with bit 8 (kernel read) clear gives fault code 1.
- R7: In the level-3 PTE, bit 8+mode grants read and execute, and bit 12+mode grants write. A non-zero request that overlaps none of these rights gives fault code 1.
- R8: Level-3 bits 1, 2 and 3 remove read, write and execute in that order. If a non-zero request then overlaps no remaining right, the fault is code 5 (execute requested), else code 4 (write), else code 3 (read). The reported rights are those that remain.
- R9: A zero access mask never yields codes 1, 3, 4 or 5 at level 3 and returns the remaining rights with fault code 0.
- R10: The read request holds valid and a stable address until ready is seen. Only one read is outstanding at a time. A response of any latency of one or more cycles is accepted.
- R11: Done is a single-cycle pulse, and done_ok is high with it exactly when the fault code is 0. req_ready is high only while the walker is idle.
- R12: After reset, req_ready is 1 and done and mem_rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start a lookup |
| req_ready | output | 1 | Walker idle, lookup accepted |
| req_va | input | 64 | Virtual address |
| req_acc | input | 3 | Requested access: bit 0 read, bit 1 write, bit 2 execute |
| req_mode | input | 2 | Privilege mode index, 0 = kernel |
| tbl_base | input | 64 | Physical address of the level-1 table |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 64 | Physical address of the PTE to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | PTE read from memory |
| done | output | 1 | One-cycle result strobe |
| done_ok | output | 1 | Translation succeeded (fault code 0) |
| done_fault | output | 3 | 0 none, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |
| done_pa | output | 64 | Physical address |
| done_prot | output | 3 | Granted rights, same encoding as req_acc |

## Verification
The bench uses the default parameters: 43 implemented address bits, 13 page bits and 10-bit indices per level. With these, the kernel-window bit relocation from 40 to 43 and the exact table-entry addresses at all three levels can be checked against fixed arithmetic. The bench memory model runs with a one-cycle response and ready always high in most tests, and with a three-cycle response and a toggling ready in one walk. The toggling ready exercises the hold-until-accepted rule and long waits for a response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } ptw_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_L1, ST_L2, ST_L3, ST_DONE
  } ptw_state_e;

  localparam int unsigned ACC_R     = 0;
  localparam int unsigned ACC_W     = 1;
  localparam int unsigned ACC_X     = 2;
  localparam int unsigned PTE_VLD   = 0;
  localparam int unsigned PTE_KRD   = 8;
  localparam int unsigned PTE_KWR   = 12;
  localparam int unsigned FRAME_LSB = 32;
endpackage

// File: rtl/ptw_precheck.sv
module ptw_precheck #(
  parameter int unsigned VA_BITS  = 43,
  parameter int unsigned WIN_LSB  = 41,
  parameter int unsigned MOVE_SRC = 40,
  parameter int unsigned MOVE_DST = 43
) (
  input  logic [63:0] va,
  output logic        canonical,
  output logic        kwindow,
  output logic [63:0] kwin_pa
);
  localparam int unsigned EXT_W = 64 - VA_BITS;

  assign canonical = (va[63:VA_BITS] == {EXT_W{va[63]}});
  assign kwindow   = va[63] && (va[WIN_LSB+1:WIN_LSB] == 2'b10);

  always_comb begin
    kwin_pa                 = '0;
    kwin_pa[MOVE_SRC-1:0]   = va[MOVE_SRC-1:0];
    kwin_pa[MOVE_DST]       = va[MOVE_SRC];
  end
endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned IDX_BITS  = 10
) (
  input  logic [PAGE_BITS+3*IDX_BITS-1:0] va_low,
  input  logic [1:0]                      level,
  input  logic [63:0]                     base,
  output logic [63:0]                     entry_addr
);
  localparam int unsigned PAD_W = 64 - IDX_BITS - 3;

  logic [IDX_BITS-1:0] idx;

  always_comb begin
    case (level)
      2'd0:    idx = va_low[PAGE_BITS+2*IDX_BITS +: IDX_BITS];
      2'd1:    idx = va_low[PAGE_BITS+IDX_BITS   +: IDX_BITS];
      default: idx = va_low[PAGE_BITS            +: IDX_BITS];
    endcase
    entry_addr = base + {{PAD_W{1'b0}}, idx, 3'b000};
  end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
(
  input  logic [15:0] pte_lo,
  input  logic [2:0]  acc,
  input  logic [1:0]  mode,
  output logic [2:0]  fault,
  output logic [2:0]  prot
);
  logic       rd_en, wr_en;
  logic [2:0] granted, kept;

  always_comb begin
    rd_en   = pte_lo[PTE_KRD + 32'(mode)];
    wr_en   = pte_lo[PTE_KWR + 32'(mode)];
    granted = {rd_en, wr_en, rd_en};
    kept    = granted & ~pte_lo[3:1];
    fault   = FLT_NONE;
    prot    = kept;
    if (!pte_lo[PTE_VLD]) begin
      fault = FLT_TNV;
      prot  = '0;
    end else if ((acc != 3'b000) && ((granted & acc) == 3'b000)) begin
      fault = FLT_ACV;
      prot  = granted;
    end else if ((acc != 3'b000) && ((kept & acc) == 3'b000)) begin
      if (acc[ACC_X])      fault = FLT_FOE;
      else if (acc[ACC_W]) fault = FLT_FOW;
      else                 fault = FLT_FOR;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_BITS   = 43,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned IDX_BITS  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_va,
  input  logic [2:0]  req_acc,
  input  logic [1:0]  req_mode,
  input  logic [63:0] tbl_base,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [63:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic        done_ok,
  output logic [2:0]  done_fault,
  output logic [63:0] done_pa,
  output logic [2:0]  done_prot
);
  localparam int unsigned WALK_W = PAGE_BITS + 3*IDX_BITS;
  localparam int unsigned FRM_W  = 64 - FRAME_LSB;

  // reset synchroniser: assert asynchronously, release on the clock
  logic rst_meta_n, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  ptw_state_e  state_q, state_d;
  logic [63:0] va_q, va_d, base_q, base_d, pa_q, pa_d;
  logic [2:0]  acc_q, acc_d, fault_q, fault_d, prot_q, prot_d;
  logic [1:0]  mode_q, mode_d;
  logic        pend_q, pend_d;

  logic        canonical, kwindow;
  logic [63:0] kwin_pa, entry_addr, next_base;
  logic [1:0]  level;
  logic [2:0]  leaf_fault, leaf_prot;

  ptw_precheck #(.VA_BITS(VA_BITS)) u_pre (
    .va(va_q), .canonical(canonical), .kwindow(kwindow), .kwin_pa(kwin_pa)
  );

  always_comb begin
    case (state_q)
      ST_L1:   level = 2'd0;
      ST_L2:   level = 2'd1;
      default: level = 2'd2;
    endcase
  end

  ptw_index #(.PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS)) u_idx (
    .va_low(va_q[WALK_W-1:0]), .level(level), .base(base_q), .entry_addr(entry_addr)
  );

  ptw_leaf_eval u_leaf (
    .pte_lo(mem_rsp_data[15:0]), .acc(acc_q), .mode(mode_q),
    .fault(leaf_fault), .prot(leaf_prot)
  );

  assign next_base = {{FRM_W{1'b0}}, mem_rsp_data[63:FRAME_LSB]} << PAGE_BITS;

  // next-state process
  always_comb begin
    state_d = state_q;
    va_d    = va_q;
    acc_d   = acc_q;
    mode_d  = mode_q;
    base_d  = base_q;
    pend_d  = pend_q;
    fault_d = fault_q;
    pa_d    = pa_q;
    prot_d  = prot_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d    = req_va;
          acc_d   = req_acc;
          mode_d  = req_mode;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        pa_d    = '0;
        prot_d  = '0;
        fault_d = FLT_NONE;
        if (!canonical) begin
          fault_d = FLT_ACV;
          state_d = ST_DONE;
        end else if (kwindow) begin
          if (mode_q != 2'd0) begin
            fault_d = FLT_ACV;
          end else begin
            pa_d   = kwin_pa;
            prot_d = 3'b111;
          end
          state_d = ST_DONE;
        end else begin
          base_d  = tbl_base;
          state_d = ST_L1;
        end
      end
      ST_L1, ST_L2, ST_L3: begin
        if (!pend_q) begin
          if (mem_rd_ready) pend_d = 1'b1;
        end else if (mem_rsp_valid) begin
          pend_d = 1'b0;
          if (state_q == ST_L3) begin
            fault_d = leaf_fault;
            prot_d  = leaf_prot;
            pa_d    = next_base | {{(64-PAGE_BITS){1'b0}}, va_q[PAGE_BITS-1:0]};
            state_d = ST_DONE;
          end else if (!mem_rsp_data[PTE_VLD]) begin
            fault_d = FLT_TNV;
            state_d = ST_DONE;
          end else if (!mem_rsp_data[PTE_KRD]) begin
            fault_d = FLT_ACV;
            state_d = ST_DONE;
          end else begin
            base_d  = next_base;
            state_d = (state_q == ST_L1) ? ST_L2 : ST_L3;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      mode_q  <= '0;
      base_q  <= '0;
      pend_q  <= 1'b0;
      fault_q <= FLT_NONE;
      pa_q    <= '0;
      prot_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (state_q == ST_IDLE) begin
        va_q   <= va_d;
        acc_q  <= acc_d;
        mode_q <= mode_d;
      end
      if (state_q != ST_IDLE) begin
        base_q  <= base_d;
        fault_q <= fault_d;
        pa_q    <= pa_d;
        prot_q  <= prot_d;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = ((state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_L3)) && !pend_q;
  assign mem_rd_addr  = entry_addr;
  assign done         = (state_q == ST_DONE);
  assign done_ok      = done && (fault_q == FLT_NONE);
  assign done_fault   = fault_q;
  assign done_pa      = pa_q;
  assign done_prot    = prot_q;
endmodule

// File: rtl/ptw_walker_checker.sv
module ptw_walker_checker #(
  parameter int unsigned VA_BITS = 43
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_va,
  input logic [1:0]  req_mode,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [63:0] mem_rd_addr,
  input logic        done,
  input logic        done_ok,
  input logic [2:0]  done_fault,
  input logic [2:0]  done_prot
);
  logic accept, noncanon, inwin;
  assign accept   = req_valid && req_ready;
  assign noncanon = (req_va[63:VA_BITS] != {(64-VA_BITS){req_va[63]}});
  assign inwin    = req_va[63] && (req_va[42:41] == 2'b10);

  p_noncanon_acv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && noncanon) |=> !mem_rd_valid ##1 (done && done_fault == 3'd1));

  p_kwin_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !noncanon && inwin && req_mode == 2'd0) |=> !mem_rd_valid ##1 (done && done_ok && done_prot == 3'b111));

  p_kwin_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !noncanon && inwin && req_mode != 2'd0) |=> ##1 (done && done_fault == 3'd1));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rd_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_ok_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_ok == (done_fault == 3'd0)));
endmodule

bind ptw_walker ptw_walker_checker #(.VA_BITS(VA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_mode(req_mode), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .done(done),
  .done_ok(done_ok), .done_fault(done_fault), .done_prot(done_prot)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] TBL = 64'h0001_0000;
  localparam logic [63:0] F_V = 64'h1, F_KR = 64'h100, F_KW = 64'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [2:0]  req_acc = '0;
  logic [1:0]  req_mode = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b1;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, done_ok;
  logic [2:0]  done_fault, done_prot;
  logic [63:0] done_pa;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .req_mode(req_mode), .tbl_base(TBL),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_ok(done_ok), .done_fault(done_fault),
    .done_pa(done_pa), .done_prot(done_prot)
  );

  // memory model
  logic [63:0] mem [logic [63:0]];
  int          lat_cfg = 1;
  logic        stall_en = 1'b0;
  int          lat_cnt = 0;
  logic [63:0] lat_addr = '0;
  int          rd_count = 0;

  always @(posedge clk) begin
    mem_rd_ready  <= stall_en ? ~mem_rd_ready : 1'b1;
    mem_rsp_valid <= 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(lat_addr) ? mem[lat_addr] : 64'h0;
      end
    end else if (mem_rd_valid && mem_rd_ready) begin
      lat_addr <= mem_rd_addr;
      lat_cnt  <= lat_cfg;
      rd_count <= rd_count + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [31:0] frame, input logic [63:0] flags);
    return {frame, 32'h0} | flags;
  endfunction

  function automatic logic [63:0] tbl_of(input logic [63:0] pte);
    return {32'h0, pte[63:32]} << 13;
  endfunction

  task automatic setup(input logic [63:0] va, input logic [63:0] p1,
                       input logic [63:0] p2, input logic [63:0] p3);
    mem.delete();
    mem[TBL + 64'(va[42:33]) * 8] = p1;
    mem[tbl_of(p1) + 64'(va[32:23]) * 8] = p2;
    mem[tbl_of(p2) + 64'(va[22:13]) * 8] = p3;
  endtask

  logic [2:0]  r_flt, r_prot;
  logic [63:0] r_pa;
  logic        r_ok;
  int          r_nrd, r_lat;

  task automatic translate(input logic [63:0] va, input logic [2:0] acc, input logic [1:0] mode);
    int start_rd;
    int k;
    @(negedge clk);
    start_rd  = rd_count;
    req_va    = va;
    req_acc   = acc;
    req_mode  = mode;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      r_lat++;
      k++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11: no done pulse, actual 0 expected 1");
    end
    r_flt  = done_fault;
    r_prot = done_prot;
    r_pa   = done_pa;
    r_ok   = done_ok;
    r_nrd  = rd_count - start_rd;
    @(negedge clk);
    chk("R11 done single pulse", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk("R12 req_ready after reset", 64'(req_ready), 64'd1);
    chk("R12 done after reset", 64'(done), 64'd0);
    chk("R12 rd_valid after reset", 64'(mem_rd_valid), 64'd0);
  endtask

  task automatic t_noncanon;
    translate(64'h0000_0800_0000_1000, 3'b001, 2'd0);
    chk("R1 fault code", 64'(r_flt), 64'd1);
    chk("R1 no reads", 64'(r_nrd), 64'd0);
    chk("R1 latency", 64'(r_lat), 64'd2);
  endtask

  task automatic t_kwindow;
    translate(64'hFFFF_FD00_1234_5678, 3'b010, 2'd0);
    chk("R2 ok", 64'(r_ok), 64'd1);
    chk("R2 pa", r_pa, 64'h0000_0800_1234_5678);
    chk("R2 prot", 64'(r_prot), 64'd7);
    chk("R2 no reads", 64'(r_nrd), 64'd0);
    translate(64'hFFFF_FD00_1234_5678, 3'b001, 2'd1);
    chk("R3 user window fault", 64'(r_flt), 64'd1);
    chk("R3 ok low", 64'(r_ok), 64'd0);
  endtask

  task automatic t_walk_ok;
    logic [63:0] va;
    va = 64'h0000_0123_4567_89AB;
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V | F_KR),
          mk_pte(32'h7ABC, F_V | F_KR | F_KW));
    translate(va, 3'b001, 2'd0);
    chk("R4 fault", 64'(r_flt), 64'd0);
    chk("R4 pa", r_pa, (64'h7ABC << 13) | 64'(va[12:0]));
    chk("R4 three reads", 64'(r_nrd), 64'd3);
    chk("R7 kernel prot", 64'(r_prot), 64'd7);
  endtask

  task automatic t_user_rights;
    logic [63:0] va;
    va = 64'h0000_0000_0ABC_DE00;
    setup(va, mk_pte(32'h21, F_V | F_KR), mk_pte(32'h31, F_V | F_KR),
          mk_pte(32'h55, F_V | 64'h8000));
    translate(va, 3'b010, 2'd3);
    chk("R7 user write ok", 64'(r_flt), 64'd0);
    chk("R7 user write prot", 64'(r_prot), 64'd2);
    translate(va, 3'b001, 2'd3);
    chk("R7 user read denied", 64'(r_flt), 64'd1);
    translate(va, 3'b010, 2'd0);
    chk("R7 kernel bit absent", 64'(r_flt), 64'd1);
  endtask

  task automatic t_invalid;
    logic [63:0] va;
    va = 64'h0000_0002_0000_4000;
    setup(va, 64'h0, mk_pte(32'h30, F_V | F_KR), mk_pte(32'h40, F_V | F_KR));
    translate(va, 3'b001, 2'd0);
    chk("R5 L1 invalid", 64'(r_flt), 64'd2);
    chk("R5 L1 reads", 64'(r_nrd), 64'd1);
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_KR), mk_pte(32'h40, F_V | F_KR));
    translate(va, 3'b001, 2'd0);
    chk("R5 L2 invalid", 64'(r_flt), 64'd2);
    chk("R5 L2 reads", 64'(r_nrd), 64'd2);
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V | F_KR), mk_pte(32'h40, F_KR | F_KW));
    translate(va, 3'b001, 2'd0);
    chk("R5 L3 invalid", 64'(r_flt), 64'd2);
    chk("R5 L3 reads", 64'(r_nrd), 64'd3);
  endtask

  task automatic t_no_kread;
    logic [63:0] va;
    va = 64'h0000_0003_0080_2000;
    setup(va, mk_pte(32'h20, F_V), mk_pte(32'h30, F_V | F_KR), mk_pte(32'h40, F_V | F_KR));
    translate(va, 3'b001, 2'd0);
    chk("R6 L1 no kread", 64'(r_flt), 64'd1);
    chk("R6 L1 reads", 64'(r_nrd), 64'd1);
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V), mk_pte(32'h40, F_V | F_KR));
    translate(va, 3'b001, 2'd0);
    chk("R6 L2 no kread", 64'(r_flt), 64'd1);
    chk("R6 L2 reads", 64'(r_nrd), 64'd2);
  endtask

  task automatic t_fault_on;
    logic [63:0] va;
    va = 64'h0000_0004_1000_6000;
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V | F_KR),
          mk_pte(32'h44, F_V | F_KR | F_KW | 64'h8));
    translate(va, 3'b100, 2'd0);
    chk("R8 fault on execute", 64'(r_flt), 64'd5);
    translate(va, 3'b001, 2'd0);
    chk("R8 read still fine", 64'(r_flt), 64'd0);
    chk("R8 exec removed", 64'(r_prot), 64'd3);
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V | F_KR),
          mk_pte(32'h44, F_V | F_KR | F_KW | 64'h4));
    translate(va, 3'b010, 2'd0);
    chk("R8 fault on write", 64'(r_flt), 64'd4);
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V | F_KR),
          mk_pte(32'h44, F_V | F_KR | F_KW | 64'h2));
    translate(va, 3'b001, 2'd0);
    chk("R8 fault on read", 64'(r_flt), 64'd3);
    chk("R8 read removed", 64'(r_prot), 64'd6);
  endtask

  task automatic t_debug;
    logic [63:0] va;
    va = 64'h0000_0005_0000_8010;
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V | F_KR), mk_pte(32'h66, F_V));
    translate(va, 3'b000, 2'd0);
    chk("R9 no rights no fault", 64'(r_flt), 64'd0);
    chk("R9 pa", r_pa, (64'h66 << 13) | 64'h10);
    setup(va, mk_pte(32'h20, F_V | F_KR), mk_pte(32'h30, F_V | F_KR),
          mk_pte(32'h66, F_V | F_KR | F_KW | 64'hE));
    translate(va, 3'b000, 2'd0);
    chk("R9 fault-on bits ignored", 64'(r_flt), 64'd0);
    chk("R9 prot all cleared", 64'(r_prot), 64'd0);
  endtask

  task automatic t_slow_mem;
    logic [63:0] va;
    va = 64'h0000_0006_0123_A000;
    lat_cfg  = 3;
    stall_en = 1'b1;
    setup(va, mk_pte(32'h22, F_V | F_KR), mk_pte(32'h33, F_V | F_KR),
          mk_pte(32'h1234, F_V | F_KR));
    translate(va, 3'b100, 2'd0);
    chk("R10 slow walk fault", 64'(r_flt), 64'd0);
    chk("R10 slow walk pa", r_pa, (64'h1234 << 13) | 64'(va[12:0]));
    chk("R10 slow walk reads", 64'(r_nrd), 64'd3);
    lat_cfg  = 1;
    stall_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_noncanon();
    t_kwindow();
    t_walk_ok();
    t_user_rights();
    t_invalid();
    t_no_kread();
    t_fault_on();
    t_debug();
    t_slow_mem();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule